// File: doc/BRIEF.md
# Five-Pin Multi-Mode GPIO Controller

This block gives five general-purpose pins a register interface through a plain synchronous port. Each pin is set to one of four modes: alternate function, input, open-drain output or push-pull output. From its mode, its output data bit and its pull bit, the block computes the pad controls: output enable, output data, pull-up and pull-down.

Pad levels pass through a two-flop synchroniser and then appear in a read-only status register. A pin in input mode raises its own interrupt when its synchronised level moves to the active level chosen by the pin's type bit. The pending bit stays set until software writes a 1 to that bit.

Two pins share each configuration byte, one nibble per pin. The pull bit has no fixed direction: it pulls down in input mode, pulls up in open-drain mode and does nothing in the other two modes. Read data is combinational from the address. A write takes effect on the rising clock edge while `bus_we` is high.

Top module: `mgpio_ctrl`

## Requirements
- R1: After reset, every pin is in input mode (code 01) with type 0. Configuration registers 0, 1 and 2 read 0x11, 0x11 and 0x01. Output data (address 4), pull (address 6) and pending (address 7) read 0. No pad is driven or pulled, and `irq` is 0.
- R2: Pin n is configured in register n>>1, in the nibble that starts at bit 4*(n%2). Nibble bits [1:0] hold the mode (00 alternate, 01 input, 10 open-drain, 11 push-pull) and bit 2 holds the type (1 = active-high, 0 = active-low). Nibble bit 3 and the unused upper nibble of register 2 read 0.
- R3: A push-pull pin has its output enable at 1 and its pad output equal to its data bit at address 4 (bit n).
- R4: An open-drain pin drives low (output enable 1, output 0) when its data bit is 0. When its data bit is 1 it releases the pad (output enable 0).
- R5: Pins in input or alternate mode never enable the pad driver, whatever their data bit.
- R6: Pull bit n (address 6) drives `pad_pd[n]` when the pin is in input mode and `pad_pu[n]` when it is in open-drain mode. In any other mode it drives neither output.
- R7: Status bit n (address 5) shows `pad_in[n]` after two clock edges, and not after one. Writes to address 5 are ignored.
- R8: A pin in input mode sets pending bit n (address 7) and `irq[n]` when its synchronised level changes to the active level. A change to the inactive level, or any change while the pin is in another mode, leaves the pending bit clear.
- R9: Writing 1 to pending bit n clears it. Pending bits written with 0 keep their value.
- R10: Address 4 reads back the output data bits. Addresses 3 and 8 to 15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| pad_in | input | NUM_PINS | Raw pad levels |
| pad_oe | output | NUM_PINS | Pad driver enable |
| pad_out | output | NUM_PINS | Pad driven level |
| pad_pu | output | NUM_PINS | Pull-up enable |
| pad_pd | output | NUM_PINS | Pull-down enable |
| irq | output | NUM_PINS | Per-pin pending interrupt |

## Verification
The bench builds the block with the default five pins, two synchroniser stages and a 4-bit address. The odd pin count means the last configuration register holds only one pin, so its empty nibble is tested. The 4-bit address covers both the gap at address 3 and the unmapped addresses above 7. With two stages the bench can sample status exactly one edge and two edges after a pad change, which checks the latency directly. The bench also drives active and inactive edges under both type settings, and toggles pins that are not in input mode to confirm those edges raise no interrupt.

// File: rtl/mgpio_pkg.sv
// Shared constants and types for the multi-mode GPIO controller.
// Assumes an 8-bit register width, with two pins packed per configuration byte.
package mgpio_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        PM_ALT = 2'b00,
        PM_IN  = 2'b01,
        PM_OD  = 2'b10,
        PM_PP  = 2'b11
    } pin_mode_e;

    localparam int A_DOUT = 4;
    localparam int A_STAT = 5;
    localparam int A_PULL = 6;
    localparam int A_PEND = 7;
endpackage

// File: rtl/mgpio_sync.sv
// Multi-stage synchroniser for the pad inputs.
// Assumes the inputs are asynchronous levels; every stage resets to 0.
module mgpio_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    // Shift the raw levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) st[s] <= '0;
        end else begin
            st[0] <= d;
            for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/mgpio_pad_drive.sv
// Computes per-pin pad enables from mode, data and pull bits.
// Purely combinational; alternate-function data is handled outside this block.
module mgpio_pad_drive
    import mgpio_pkg::*;
#(
    parameter int NUM_PINS = 5
) (
    input  logic [2*NUM_PINS-1:0] mode_flat,
    input  logic [NUM_PINS-1:0]   dout,
    input  logic [NUM_PINS-1:0]   pull,
    output logic [NUM_PINS-1:0]   oe,
    output logic [NUM_PINS-1:0]   out,
    output logic [NUM_PINS-1:0]   pu,
    output logic [NUM_PINS-1:0]   pd
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_mode_e m;
        assign m = pin_mode_e'(mode_flat[2*p +: 2]);

        // Select the driver and pull behaviour for one pin.
        always_comb begin
            oe[p]  = 1'b0;
            out[p] = 1'b0;
            pu[p]  = 1'b0;
            pd[p]  = 1'b0;
            case (m)
                PM_PP: begin
                    oe[p]  = 1'b1;
                    out[p] = dout[p];
                end
                PM_OD: begin
                    oe[p] = ~dout[p];
                    pu[p] = pull[p];
                end
                PM_IN:   pd[p] = pull[p];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mgpio_edge_evt.sv
// Detects, for pins in input mode, a change of the synchronised level to the active level.
// Assumes lvl is already synchronous; the previous-level register resets to 0.
module mgpio_edge_evt #(
    parameter int NUM_PINS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] active_hi,
    input  logic [NUM_PINS-1:0] in_mode,
    output logic [NUM_PINS-1:0] evt
);
    logic [NUM_PINS-1:0] prev_q;

    // Remember the last synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign evt = in_mode & (lvl ^ prev_q) & ~(lvl ^ active_hi);
endmodule

// File: rtl/mgpio_ctrl.sv
// Register-mapped five-pin GPIO controller: register decode, pad control,
// input synchronisation and per-pin event interrupts.
// Assumes NUM_PINS <= 8 and single-cycle write strobes; read data is combinational.
module mgpio_ctrl
    import mgpio_pkg::*;
#(
    parameter int NUM_PINS    = 5,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_pu,
    output logic [NUM_PINS-1:0] pad_pd,
    output logic [NUM_PINS-1:0] irq
);
    localparam int NUM_CFG = (NUM_PINS + 1) / 2;

    pin_mode_e           mode_q [NUM_PINS];
    logic [NUM_PINS-1:0] type_q;
    logic [NUM_PINS-1:0] dout_q;
    logic [NUM_PINS-1:0] pull_q;
    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] lvl_sync;
    logic [NUM_PINS-1:0] in_mode;
    logic [NUM_PINS-1:0] evt;
    logic [2*NUM_PINS-1:0] mode_flat;
    logic                unused_wbits;

    assign unused_wbits = bus_wdata[3] ^ bus_wdata[7];

    // Per-pin configuration nibble storage.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[p] <= PM_IN;
                type_q[p] <= 1'b0;
            end else if (bus_we && bus_addr == ADDR_W'(p / 2)) begin
                mode_q[p] <= pin_mode_e'(bus_wdata[4*(p%2) +: 2]);
                type_q[p] <= bus_wdata[4*(p%2) + 2];
            end
        end
        assign mode_flat[2*p +: 2] = mode_q[p];
        assign in_mode[p]          = (mode_q[p] == PM_IN);
    end

    // Output data, pull enables and write-1-to-clear pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            pull_q <= '0;
            pend_q <= '0;
        end else begin
            if (bus_we && bus_addr == ADDR_W'(A_DOUT)) dout_q <= bus_wdata[NUM_PINS-1:0];
            if (bus_we && bus_addr == ADDR_W'(A_PULL)) pull_q <= bus_wdata[NUM_PINS-1:0];
            if (bus_we && bus_addr == ADDR_W'(A_PEND))
                pend_q <= (pend_q & ~bus_wdata[NUM_PINS-1:0]) | evt;
            else
                pend_q <= pend_q | evt;
        end
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(NUM_CFG)) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (bus_addr == ADDR_W'(p / 2))
                    bus_rdata[4*(p%2) +: 3] = {type_q[p], mode_q[p]};
            end
        end else begin
            case (int'(bus_addr))
                A_DOUT:  bus_rdata[NUM_PINS-1:0] = dout_q;
                A_STAT:  bus_rdata[NUM_PINS-1:0] = lvl_sync;
                A_PULL:  bus_rdata[NUM_PINS-1:0] = pull_q;
                A_PEND:  bus_rdata[NUM_PINS-1:0] = pend_q;
                default: ;
            endcase
        end
    end

    mgpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (lvl_sync)
    );

    mgpio_edge_evt #(.NUM_PINS(NUM_PINS)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_sync),
        .active_hi(type_q),
        .in_mode  (in_mode),
        .evt      (evt)
    );

    mgpio_pad_drive #(.NUM_PINS(NUM_PINS)) u_pad (
        .mode_flat(mode_flat),
        .dout     (dout_q),
        .pull     (pull_q),
        .oe       (pad_oe),
        .out      (pad_out),
        .pu       (pad_pu),
        .pd       (pad_pd)
    );

    assign irq = pend_q;
endmodule

// File: rtl/mgpio_checker.sv
// Property checker for mgpio_ctrl, attached through bind.
// Observes ports plus the flattened mode vector.
module mgpio_checker #(
    parameter int NUM_PINS = 5,
    parameter int ADDR_W   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [7:0]            bus_wdata,
    input logic [2*NUM_PINS-1:0] mode_flat,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_pu,
    input logic [NUM_PINS-1:0]   pad_pd,
    input logic [NUM_PINS-1:0]   irq
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // An open-drain pin never drives high.
        assert_od_low_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_flat[2*i +: 2] == 2'b10 && pad_oe[i]) |-> !pad_out[i]);

        // The driver stays off in input and alternate modes.
        assert_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_flat[2*i +: 2] == 2'b00 || mode_flat[2*i +: 2] == 2'b01) |-> !pad_oe[i]);

        // A pin is never pulled both ways.
        assert_pull_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(pad_pu[i] && pad_pd[i]));

        // A pending bit only rises for a pin that was in input mode.
        assert_irq_input_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> $past(mode_flat[2*i +: 2]) == 2'b01);

        // Writing 1 clears the bit when no new event can arrive.
        assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && int'(bus_addr) == 7 && bus_wdata[i] && mode_flat[2*i +: 2] != 2'b01)
            |=> !irq[i]);
    end
endmodule

bind mgpio_ctrl mgpio_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .mode_flat(mode_flat),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .pad_pu   (pad_pu),
    .pad_pd   (pad_pd),
    .irq      (irq)
);

// File: tb/mgpio_ctrl_bench.sv
// Directed bench for mgpio_ctrl: one task per scenario, each checking its own results.
module mgpio_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_oe, pad_out, pad_pu, pad_pd, irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgpio_ctrl u_mgpio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 cfg0", 0, 8'h11);
        rd_chk("R1 cfg1", 1, 8'h11);
        rd_chk("R1 cfg2", 2, 8'h01);
        rd_chk("R1 dout", 4, 8'h00);
        rd_chk("R1 pull", 6, 8'h00);
        rd_chk("R1 pend", 7, 8'h00);
        chk("R1 pad_oe", 8'(pad_oe), 8'h00);
        chk("R1 pulls", 8'(pad_pu | pad_pd), 8'h00);
        chk("R1 irq", 8'(irq), 8'h00);
    endtask

    task automatic t_layout;
        wr(0, 8'hFF);
        rd_chk("R2 cfg0 reserved bits", 0, 8'h77);
        wr(2, 8'hFE);
        rd_chk("R2 cfg2 pin4 only", 2, 8'h06);
        wr(0, 8'h11);
        wr(2, 8'h01);
        rd_chk("R2 cfg0 restore", 0, 8'h11);
    endtask

    task automatic t_pushpull;
        wr(1, 8'h33);
        wr(4, 8'h04);
        chk("R3 pp oe", 8'(pad_oe), 8'h0C);
        chk("R3 pp out", 8'(pad_out), 8'h04);
        rd_chk("R10 dout readback", 4, 8'h04);
    endtask

    task automatic t_opendrain;
        wr(2, 8'h02);
        wr(4, 8'h04);
        chk("R4 od drive low oe", 8'(pad_oe & 5'h10), 8'h10);
        chk("R4 od drive low out", 8'(pad_out & 5'h10), 8'h00);
        wr(4, 8'h14);
        chk("R4 od release", 8'(pad_oe & 5'h10), 8'h00);
    endtask

    task automatic t_input_alt;
        wr(1, 8'h10);
        wr(4, 8'h1F);
        chk("R5 in/alt no drive", 8'(pad_oe), 8'h00);
    endtask

    task automatic t_pull;
        wr(6, 8'h1F);
        chk("R6 pull-down in input", 8'(pad_pd), 8'h0B);
        chk("R6 pull-up in open-drain", 8'(pad_pu), 8'h10);
        wr(1, 8'h33);
        chk("R6 no pull in pp", 8'(pad_pd), 8'h03);
        wr(6, 8'h00);
        wr(4, 8'h00);
    endtask

    task automatic t_status;
        @(negedge clk);
        pad_in = 5'h15;
        @(negedge clk);
        rd_chk("R7 status after one edge", 5, 8'h00);
        @(negedge clk);
        rd_chk("R7 status after two edges", 5, 8'h15);
        wr(5, 8'h00);
        rd_chk("R7 status write ignored", 5, 8'h15);
        pad_in = 5'h00;
        idle(4);
    endtask

    task automatic t_irq;
        wr(0, 8'h15);
        wr(1, 8'h33);
        wr(2, 8'h01);
        idle(4);
        wr(7, 8'h1F);
        rd_chk("R8 pend cleared", 7, 8'h00);
        pad_in = 5'h01; idle(5);
        rd_chk("R8 active-high rise", 7, 8'h01);
        chk("R8 irq out", 8'(irq), 8'h01);
        wr(7, 8'h01);
        pad_in = 5'h00; idle(5);
        rd_chk("R8 inactive fall", 7, 8'h00);
        pad_in = 5'h02; idle(5);
        rd_chk("R8 inactive rise low-type", 7, 8'h00);
        pad_in = 5'h00; idle(5);
        rd_chk("R8 active-low fall", 7, 8'h02);
        wr(7, 8'h02);
        pad_in = 5'h04; idle(5);
        pad_in = 5'h00; idle(5);
        rd_chk("R8 non-input pin no event", 7, 8'h00);
    endtask

    task automatic t_w1c;
        pad_in = 5'h01; idle(5);
        pad_in = 5'h03; idle(5);
        pad_in = 5'h01; idle(5);
        rd_chk("R9 two pending", 7, 8'h03);
        wr(7, 8'h02);
        rd_chk("R9 partial clear", 7, 8'h01);
        chk("R9 irq after partial clear", 8'(irq), 8'h01);
        wr(7, 8'h01);
        rd_chk("R9 full clear", 7, 8'h00);
    endtask

    task automatic t_unmapped;
        wr(4, 8'h0A);
        wr(3, 8'hFF);
        wr(15, 8'hFF);
        rd_chk("R10 addr3 reads zero", 3, 8'h00);
        rd_chk("R10 addr15 reads zero", 15, 8'h00);
        rd_chk("R10 dout untouched", 4, 8'h0A);
        rd_chk("R10 cfg0 untouched", 0, 8'h15);
        rd_chk("R10 pull untouched", 6, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_pushpull();
        t_opendrain();
        t_input_alt();
        t_pull();
        t_status();
        t_irq();
        t_w1c();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule